// File: doc/BRIEF.md
# Alternating Asymmetric PWM Gate Generator

This block drives the two gates of a half-bridge from a square reference that an external loop keeps in phase with the load current. Each rising edge of the reference opens a switching cycle. The two gate outputs then get complementary, unequal conduction intervals, with a programmable dead time before each turn-on. A phase word sets how long the short interval is, and therefore how much power is delivered.

Cycles come in pairs. In the first cycle of a pair the high side holds the short interval. In the second cycle the low side holds it. Over the pair each switch conducts for the same total time, so the bridge output has no DC component and the hard turn-off moves from one device to the other every cycle. The generator measures the reference period in clock cycles, so it can place the low side's short interval at the end of the second cycle. It takes new settings only when a pair begins.

Top module: `alt_apwm_gate`

## Requirements
- R1: The two gates are never high together. Before every turn-on of either gate, both gates stay low for at least D clock cycles, where D is the dead time in force.
- R2: Suppose the reference is first sampled high at clock edge k. The synchronised edge is seen one edge later, and the cycle counter reads 0 in the cycle after edge k+1. Within a cycle, c is the counter value, counting clock cycles from that point.
- R3: In the first cycle of a pair (short high side), `gate_hi` is high for D <= c < D+P and `gate_lo` is high for c >= 2D+P until the next reference edge. P is the effective phase.
- R4: In the second cycle of a pair (short low side), `gate_hi` is high for D <= c < E, where E = T-P-D (or E = D if T <= P+D). `gate_lo` is high from c = E+D until the next reference edge, so the low side's interval is the last P cycles of a period of length T.
- R5: The two cycle kinds alternate strictly. The pair always opens with the short high-side cycle.
- R6: T is the number of clock cycles between the two most recent reference rising edges. It is taken at the edge that opens a pair and is held for both cycles of that pair.
- R7: `phase_in` and `dead_in` are sampled only at the edge that opens a pair. Changes in the middle of a pair have no effect until the next pair.
- R8: The effective phase is P = max(2D, min(phase_in, T-4D)), where T-4D is taken as 0 when T <= 4D. This keeps every conduction interval at least 2D long whenever T >= 6D.
- R9: While reset is asserted or `en` is low, both gates are low and the alternation state is cleared. After enabling, the first reference edge only starts the period count. The second edge opens a pair.
- R10: When T matches the actual reference period, each gate conducts for T-2D cycles over a pair, so the mean output voltage is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low forces both gates off |
| ref_in | input | 1 | Square reference locked to the load current |
| phase_in | input | CW | Requested short-interval length in clocks |
| dead_in | input | DW | Dead time in clocks |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
On every clock, the assertions check that the gates never overlap, that a turn-on always follows a dead gap of at least D cycles, that the gates are dark while disabled, and that a high-side pulse is never shorter than 2D. Other behaviours can only be seen from the bench's scenarios, which count pulse widths per reference window: the placement of each interval, the strict alternation, the clamping of the phase word, the deferral of new settings to a pair boundary, the period measurement and the equal conduction totals over a pair.

// File: rtl/alt_apwm_gate.sv
module alt_apwm_gate #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ref_in,
  input  logic [CW-1:0] phase_in,
  input  logic [DW-1:0] dead_in,
  output logic          gate_hi,
  output logic          gate_lo
);
  localparam int XW = CW + 2;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          ref_s1, ref_s2, primed, run, sel;
  logic [CW-1:0] cnt;
  logic [XW-1:0] t_q, p_q, d_q;

  logic ref_rise, pair_start;
  assign ref_rise   = ref_s1 & ~ref_s2;
  assign pair_start = ref_rise & primed & (~run | sel);

  logic [XW-1:0] t_new, d_new, d2, d4, ph, pmax, pa, p_new;
  assign t_new = XW'(cnt) + XW'(1);
  assign d_new = XW'(dead_in);
  assign d2    = d_new << 1;
  assign d4    = d_new << 2;
  assign ph    = XW'(phase_in);
  assign pmax  = (t_new > d4) ? t_new - d4 : '0;
  assign pa    = (ph < pmax) ? ph : pmax;
  assign p_new = (pa < d2) ? d2 : pa;

  logic [XW-1:0] c_x, e_cur, hi_end, lo_st;
  logic          active;
  assign c_x    = XW'(cnt);
  assign e_cur  = (t_q > p_q + d_q) ? t_q - p_q - d_q : d_q;
  assign hi_end = sel ? e_cur : d_q + p_q;
  assign lo_st  = sel ? e_cur + d_q : (d_q << 1) + p_q;
  assign active = rst_n & en & run;

  assign gate_hi = active & (c_x >= d_q) & (c_x < hi_end);
  assign gate_lo = active & (c_x >= lo_st);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      ref_s1 <= 1'b0;
      ref_s2 <= 1'b0;
      primed <= 1'b0;
      run    <= 1'b0;
      sel    <= 1'b0;
      cnt    <= '0;
      t_q    <= '0;
      p_q    <= '0;
      d_q    <= '0;
    end else begin
      ref_s1 <= ref_in;
      ref_s2 <= ref_s1;
      if (ref_rise) begin
        cnt <= '0;
        if (!primed) begin
          primed <= 1'b1;
        end else if (pair_start) begin
          run <= 1'b1;
          sel <= 1'b0;
          t_q <= t_new;
          d_q <= d_new;
          p_q <= p_new;
        end else begin
          sel <= 1'b1;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/alt_apwm_gate_chk.sv
module alt_apwm_gate_chk #(
  parameter int XW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          gate_hi,
  input logic          gate_lo,
  input logic [XW-1:0] dead_q,
  input logic [XW-1:0] per_q
);
  localparam logic [XW-1:0] LEN_MAX = '1;

  logic [XW-1:0] gap, hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= '0;
      hi_len <= '0;
    end else begin
      if (gate_hi || gate_lo) gap <= '0;
      else if (gap != LEN_MAX) gap <= gap + 1'b1;
      if (!gate_hi) hi_len <= '0;
      else if (hi_len != LEN_MAX) hi_len <= hi_len + 1'b1;
    end
  end

  logic [XW+2:0] two_d, six_d;
  assign two_d = (XW+3)'(dead_q) << 1;
  assign six_d = ((XW+3)'(dead_q) << 2) + two_d;

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R1
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (gap >= dead_q));

  // R9
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!gate_hi && !gate_lo));

  // R8
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $fell(gate_hi) |-> (((XW+3)'(hi_len) >= two_d) || ((XW+3)'(per_q) < six_d)));
endmodule

bind alt_apwm_gate alt_apwm_gate_chk #(.XW(XW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .gate_hi(gate_hi),
  .gate_lo(gate_lo),
  .dead_q (d_q),
  .per_q  (t_q)
);

// File: tb/test_alt_apwm_gate.sv
`timescale 1ns/1ps
module test_alt_apwm_gate;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ref_in = 1'b0;
  logic [CW-1:0] phase_in = '0;
  logic [DW-1:0] dead_in = '0;
  logic gate_hi, gate_lo;

  always #2 clk = ~clk;

  alt_apwm_gate #(.CW(CW), .DW(DW)) i_alt_apwm_gate (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_in(ref_in),
    .phase_in(phase_in), .dead_in(dead_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, integers only
  int m_h1, m_h2, m_pr, m_run, m_sel, m_c, m_t, m_p, m_d;
  always @(posedge clk) begin
    int rs, tn, pmx, pp;
    if (!rst_n || !en) begin
      m_h1 = 0; m_h2 = 0; m_pr = 0; m_run = 0; m_sel = 0;
      m_c = 0; m_t = 0; m_p = 0; m_d = 0;
    end else begin
      rs = (m_h1 == 1 && m_h2 == 0) ? 1 : 0;
      m_h2 = m_h1;
      m_h1 = int'(ref_in);
      if (rs == 1) begin
        if (m_pr == 0) m_pr = 1;
        else if (m_run == 0 || m_sel == 1) begin
          tn = m_c + 1;
          m_d = int'(dead_in);
          pmx = (tn > 4 * m_d) ? tn - 4 * m_d : 0;
          pp = (int'(phase_in) < pmx) ? int'(phase_in) : pmx;
          if (pp < 2 * m_d) pp = 2 * m_d;
          m_p = pp; m_t = tn; m_run = 1; m_sel = 0;
        end else m_sel = 1;
        m_c = 0;
      end else if (m_c < CMAX) m_c++;
    end
  end

  always begin
    int e, eh, el;
    @(negedge clk);
    #1;
    e = (m_t > m_p + m_d) ? m_t - m_p - m_d : m_d;
    eh = 0; el = 0;
    if (rst_n && en && m_run == 1) begin
      if (m_sel == 1) begin
        eh = (m_c >= m_d && m_c < e) ? 1 : 0;
        el = (m_c >= e + m_d) ? 1 : 0;
      end else begin
        eh = (m_c >= m_d && m_c < m_d + m_p) ? 1 : 0;
        el = (m_c >= 2 * m_d + m_p) ? 1 : 0;
      end
    end
    if (!done) begin
      check("R3/R4 model gate_hi", int'(gate_hi), eh);
      check("R3/R4 model gate_lo", int'(gate_lo), el);
    end
  end

  int whi, wlo;
  task automatic ref_cycle(input int n);
    whi = 0; wlo = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_in = (i < n / 2);
      #1;
      whi += int'(gate_hi);
      wlo += int'(gate_lo);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hs, ls;
    repeat (5) @(negedge clk);
    #1;
    check("R9 reset gate_hi", int'(gate_hi), 0);
    check("R9 reset gate_lo", int'(gate_lo), 0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1; phase_in = 8; dead_in = 3;
    ref_cycle(40); check("R9 priming window hi", whi, 0);
    ref_cycle(40); check("R3 short high side", whi, 8);
    ref_cycle(40); check("R4 long high side", whi, 26);
    ref_cycle(40); check("R5 alternation back to short", whi, 8);
    phase_in = 12;
    ref_cycle(40); check("R7 mid-pair phase ignored", whi, 26);
    ref_cycle(40); check("R7 phase taken at pair start", whi, 12);
    ref_cycle(40); check("R4 second cycle new phase", whi, 22);
    ref_cycle(40); hs = whi; ls = wlo;
    ref_cycle(40); hs += whi; ls += wlo;
    check("R10 pair high total", hs, 34);
    check("R10 pair low total", ls, 34);
    phase_in = 1;
    ref_cycle(40); check("R8 clamp low short", whi, 6);
    ref_cycle(40); check("R8 clamp low long", whi, 28);
    phase_in = 100;
    ref_cycle(40); check("R8 clamp high short", whi, 28);
    ref_cycle(40); check("R8 clamp high long", whi, 6);
    dead_in = 5; phase_in = 10;
    ref_cycle(50); check("R1 new dead time short", whi, 10);
    ref_cycle(50); check("R6 period from previous cycle", whi, 20);
    ref_cycle(50); check("R3 steady at longer period", whi, 10);
    ref_cycle(50); check("R6 period re-measured", whi, 30);
    dead_in = 2; phase_in = 6;
    ref_cycle(30);
    ref_cycle(30);
    ref_cycle(30);
    ref_cycle(30); check("R6 shorter period long side", whi, 20);
    @(negedge clk); #1;
    check("R4 low side holds to cycle end", int'(gate_lo), 1);
    @(negedge clk); en = 1'b0; #1;
    check("R9 disable hi", int'(gate_hi), 0);
    check("R9 disable lo", int'(gate_lo), 0);
    repeat (4) @(negedge clk);
    en = 1'b1;
    ref_cycle(30); check("R9 prime after enable", whi, 0);
    ref_cycle(30); check("R5 pair restarts short high", whi, 6);
    ref_cycle(30); check("R2 second cycle after restart", whi, 20);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule